// File: doc/BRIEF.md
# Decode-Stage Load-Use Stall and Redirect Flush Controller

This block sits beside the decode stage of a five-stage in-order pipeline. It holds the front of the pipeline for a single cycle when the instruction now in decode reads a register that a load, currently in execute, has not yet brought back from memory. While the front is held, it asks the control path to put a bubble into the decode/execute register. Only the instruction directly behind the load is examined. An instruction two slots behind the load receives its value through other means and never stalls.

Branches are predicted not taken, and they are resolved in decode. A taken branch or a jump redirects fetch. The one instruction fetched behind it is the wrong one, so the block asks for the fetch/decode register to be cleared to an all-zero word (a nop) on the next clock edge. Each redirect therefore costs exactly one cycle.

A small state machine keeps each stall to one cycle and makes the cycle after a flush, whose decode slot holds the squashed nop, pass with no action. It has three states:
- `HZ_RUN`: normal operation.
- `HZ_HOLD`: the cycle after a stall.
- `HZ_SQUASH`: the cycle after a flush.

It has these transitions:
- `RUN->SQUASH` on a redirect.
- `RUN->HOLD` on a load-use hit without a redirect.
- `HOLD->SQUASH` on a redirect.
- `HOLD->RUN` otherwise.
- `SQUASH->RUN` always.
- `RUN->RUN` when nothing happens.

Top module: `dec_hazard_unit`

## Requirements
- R1: In `HZ_RUN`, a load-use hit gives `pc_wr_en`=0, `ifid_wr_en`=0, `ctl_bubble`=1 and `ifid_flush`=0 in that same cycle, with no redirect present. A load-use hit means `ex_ld_en`=1, `ex_ld_dst` is nonzero, and `ex_ld_dst` equals `id_src_a` or `id_src_b`.
- R2: If `ex_ld_en`=0, or if neither source matches `ex_ld_dst`, and no redirect is present, the outputs are pass values: `pc_wr_en`=1, `ifid_wr_en`=1, `ctl_bubble`=0 and `ifid_flush`=0. This covers a consumer two slots behind a load.
- R3: A load whose destination is register 0 never causes a stall, even when a source is also 0.
- R4: A stall lasts exactly one cycle. In the cycle after a stall (`HZ_HOLD`), a load-use hit is ignored and the outputs are pass values.
- R5: In `HZ_RUN`, `id_br_taken`=1 or `id_jump`=1 gives `ifid_flush`=1, `pc_wr_en`=1, `ifid_wr_en`=1 and `ctl_bubble`=0.
- R6: When a redirect and a load-use hit coincide, the flush wins. The outputs are the R5 values, with no bubble.
- R7: In the cycle after a flush (`HZ_SQUASH`), redirect and load-use inputs are ignored and the outputs are pass values.
- R8: After reset the machine is in `HZ_RUN`. With idle inputs the outputs are pass values, and a load-use hit in the first cycle stalls.
- R9: A redirect arriving in the cycle after a stall (`HZ_HOLD`) is honoured with the R5 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src_a | input | REG_W | First source register of the instruction in decode |
| id_src_b | input | REG_W | Second source register of the instruction in decode |
| ex_ld_dst | input | REG_W | Destination register of the instruction in execute |
| ex_ld_en | input | 1 | Instruction in execute reads data memory |
| id_br_taken | input | 1 | Branch in decode resolved taken |
| id_jump | input | 1 | Jump in decode |
| pc_wr_en | output | 1 | Program counter write enable |
| ifid_wr_en | output | 1 | Fetch/decode register write enable |
| ctl_bubble | output | 1 | Zero the control fields entering decode/execute |
| ifid_flush | output | 1 | Clear fetch/decode to an all-zero word on the next edge |

## Verification
The input patterns are chosen so that each one separates two behaviours:
- A load followed by a consumer on either source, compared with a consumer that matches only when the load enable is low, separates a true load-use hit from a plain register match.
- A load to register 0 separates the zero-register exclusion from an ordinary match.
- Hit inputs held for two cycles show that the stall ends after one cycle.
- A redirect that coincides with a hit shows the flush priority.
- A redirect in the squash cycle shows that the squash slot is ignored.
- A redirect in the hold cycle shows that the hold state still honours redirects.
- A long pseudo-random run over a small register range mixes all of these patterns and follows the state machine through every transition.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        HZ_RUN    = 2'd0,
        HZ_HOLD   = 2'd1,
        HZ_SQUASH = 2'd2
    } hz_state_e;

    typedef struct packed {
        logic pc_we;
        logic ifid_we;
        logic bubble;
        logic flush;
    } hz_ctl_t;

    localparam hz_ctl_t HZ_CTL_PASS  = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0, flush: 1'b0};
    localparam hz_ctl_t HZ_CTL_STALL = '{pc_we: 1'b0, ifid_we: 1'b0, bubble: 1'b1, flush: 1'b0};
    localparam hz_ctl_t HZ_CTL_FLUSH = '{pc_we: 1'b1, ifid_we: 1'b1, bubble: 1'b0, flush: 1'b1};

endpackage

// File: rtl/hzd_loaduse_cmp.sv
module hzd_loaduse_cmp #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                            ld_valid,
    input  logic [REG_W-1:0]                ld_dst,
    input  logic [NUM_SRC-1:0][REG_W-1:0]   src,
    output logic                            hit
);
    logic [NUM_SRC-1:0] src_match;
    logic               dst_live;

    // A destination of register 0 never carries a real result.
    assign dst_live = |ld_dst;

    // One comparator per source operand of the decode instruction.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_match[g] = (src[g] == ld_dst);
    end

    assign hit = ld_valid & dst_live & (|src_match);
endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect #(
    parameter int NUM_REDIR = 2
) (
    input  logic [NUM_REDIR-1:0] req,
    output logic                 redirect
);
    assign redirect = |req;
endmodule

// File: rtl/hzd_ctrl_fsm.sv
module hzd_ctrl_fsm
    import hzd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    lu_hit,
    input  logic    redirect,
    output hz_ctl_t ctl
);
    hz_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HZ_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d = HZ_RUN;
        ctl     = HZ_CTL_PASS;
        unique case (state_q)
            HZ_RUN: begin
                if (redirect) begin
                    ctl     = HZ_CTL_FLUSH;   // flush outranks stall
                    state_d = HZ_SQUASH;
                end else if (lu_hit) begin
                    ctl     = HZ_CTL_STALL;
                    state_d = HZ_HOLD;
                end
            end
            HZ_HOLD: begin
                // The load has moved on; only a redirect acts here.
                if (redirect) begin
                    ctl     = HZ_CTL_FLUSH;
                    state_d = HZ_SQUASH;
                end
            end
            HZ_SQUASH: begin
                // Decode holds the squashed nop.
                ctl     = HZ_CTL_PASS;
                state_d = HZ_RUN;
            end
            default: begin
                ctl     = HZ_CTL_PASS;
                state_d = HZ_RUN;
            end
        endcase
    end
endmodule

// File: rtl/dec_hazard_unit.sv
module dec_hazard_unit
    import hzd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic [REG_W-1:0] ex_ld_dst,
    input  logic             ex_ld_en,
    input  logic             id_br_taken,
    input  logic             id_jump,
    output logic             pc_wr_en,
    output logic             ifid_wr_en,
    output logic             ctl_bubble,
    output logic             ifid_flush
);
    localparam int NUM_SRC   = 2;
    localparam int NUM_REDIR = 2;

    logic [NUM_SRC-1:0][REG_W-1:0] srcs;
    logic                          lu_hit;
    logic                          redirect;
    hz_ctl_t                       ctl;

    assign srcs[0] = id_src_a;
    assign srcs[1] = id_src_b;

    hzd_loaduse_cmp #(
        .REG_W   (REG_W),
        .NUM_SRC (NUM_SRC)
    ) u_cmp (
        .ld_valid (ex_ld_en),
        .ld_dst   (ex_ld_dst),
        .src      (srcs),
        .hit      (lu_hit)
    );

    hzd_redirect #(
        .NUM_REDIR (NUM_REDIR)
    ) u_redir (
        .req      ({id_jump, id_br_taken}),
        .redirect (redirect)
    );

    hzd_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lu_hit   (lu_hit),
        .redirect (redirect),
        .ctl      (ctl)
    );

    assign pc_wr_en   = ctl.pc_we;
    assign ifid_wr_en = ctl.ifid_we;
    assign ctl_bubble = ctl.bubble;
    assign ifid_flush = ctl.flush;
endmodule

// File: rtl/hzd_checks.sv
module hzd_checks #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] id_src_a,
    input logic [REG_W-1:0] id_src_b,
    input logic [REG_W-1:0] ex_ld_dst,
    input logic             ex_ld_en,
    input logic             id_br_taken,
    input logic             id_jump,
    input logic             pc_wr_en,
    input logic             ifid_wr_en,
    input logic             ctl_bubble,
    input logic             ifid_flush
);
    logic hit_in;
    logic redir_in;

    assign hit_in   = ex_ld_en && (ex_ld_dst != '0) &&
                      ((ex_ld_dst == id_src_a) || (ex_ld_dst == id_src_b));
    assign redir_in = id_br_taken || id_jump;

    assert_stall_on_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_in && !redir_in && !$past(ctl_bubble) && !$past(ifid_flush))
            |-> (!pc_wr_en && !ifid_wr_en && ctl_bubble && !ifid_flush));

    assert_no_stall_r0_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_ld_dst == '0) |-> !ctl_bubble);

    assert_single_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_bubble |=> !ctl_bubble);

    assert_flush_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_in && !$past(ifid_flush)) |-> (ifid_flush && !ctl_bubble && pc_wr_en && ifid_wr_en));

    assert_squash_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |=> (pc_wr_en && ifid_wr_en && !ctl_bubble && !ifid_flush));

    assert_no_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_in && !redir_in) |-> (pc_wr_en && ifid_wr_en && !ctl_bubble && !ifid_flush));
endmodule

bind dec_hazard_unit hzd_checks #(.REG_W(REG_W)) u_hzd_checks (.*);

// File: tb/dec_hazard_unit_bench.sv
`timescale 1ns/1ps
module dec_hazard_unit_bench;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] rs = '0, rt = '0, ert = '0;
    logic         mr = 1'b0, tk = 1'b0, jp = 1'b0;
    logic         pc_we, ifid_we, bub, fl;

    int n_chk = 0;
    int n_bad = 0;
    int mstate = 0;          // 0 run, 1 after stall, 2 after flush
    int mnext;
    logic [3:0] mexp;

    always #4 clk = ~clk;    // 125 MHz

    dec_hazard_unit #(.REG_W(W)) u_dec_hazard_unit (
        .clk(clk), .rst_n(rst_n), .id_src_a(rs), .id_src_b(rt),
        .ex_ld_dst(ert), .ex_ld_en(mr), .id_br_taken(tk), .id_jump(jp),
        .pc_wr_en(pc_we), .ifid_wr_en(ifid_we), .ctl_bubble(bub), .ifid_flush(fl)
    );

    // Behavioural reference: {pc_we, ifid_we, bubble, flush}.
    always_comb begin
        bit haz, red;
        haz = mr && (ert != 0) && (ert == rs || ert == rt);
        red = tk || jp;
        if (mstate == 2) begin
            mexp = 4'b1100; mnext = 0;
        end else if (red) begin
            mexp = 4'b1101; mnext = 2;
        end else if (haz && mstate == 0) begin
            mexp = 4'b0010; mnext = 1;
        end else begin
            mexp = 4'b1100; mnext = 0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) mstate <= 0;
        else        mstate <= mnext;
    end

    function automatic string tag_of();
        bit haz, red;
        haz = mr && (ert != 0) && (ert == rs || ert == rt);
        red = tk || jp;
        if (mstate == 2)                     return "R7";
        if (red && haz)                      return "R6";
        if (red && mstate == 1)              return "R9";
        if (red)                             return "R5";
        if (haz && mstate == 1)              return "R4";
        if (haz)                             return "R1";
        if (mr && ert == 0 && (rs == 0 || rt == 0)) return "R3";
        return "R2";
    endfunction

    task automatic check(input string tag);
        logic [3:0] act;
        act = {pc_we, ifid_we, bub, fl};
        n_chk++;
        if (act !== mexp) begin
            n_bad++;
            $display("FAIL %s: outputs {pc_we,ifid_we,bubble,flush} actual %b expected %b", tag, act, mexp);
        end
    endtask

    // Drive at the falling edge, compare 2 ns later, well before the rising edge.
    task automatic cyc(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] d,
                       input logic l, input logic t, input logic j);
        @(negedge clk);
        rs = a; rt = b; ert = d; mr = l; tk = t; jp = j;
        #2;
        check(tag_of());
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 0);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check("R8");                          // idle after reset: pass values
        cyc(5'd2, 5'd7, 5'd2, 1, 0, 0);      // R8: first-cycle hit stalls (R1)
        cyc(5'd2, 5'd7, 5'd2, 1, 0, 0);      // R4: held inputs, no second stall
        cyc(5'd1, 5'd9, 5'd9, 1, 0, 0);      // R1: match on second source
        cyc(5'd1, 5'd9, 5'd9, 0, 0, 0);      // R4/R2 hold cycle, R2 inputs
        cyc(5'd3, 5'd4, 5'd4, 0, 0, 0);      // R2: match but not a load
        cyc(5'd1, 5'd5, 5'd2, 1, 0, 0);      // R2: load, no match
        cyc(5'd2, 5'd6, 5'd4, 0, 0, 0);      // R2: consumer two slots later
        cyc(5'd0, 5'd0, 5'd0, 1, 0, 0);      // R3: load to r0
        cyc(5'd0, 5'd3, 5'd0, 1, 0, 0);      // R3
        cyc(5'd1, 5'd2, 5'd3, 0, 1, 0);      // R5: taken branch
        cyc(5'd6, 5'd6, 5'd6, 1, 1, 1);      // R7: squash slot ignores all
        cyc(5'd1, 5'd2, 5'd3, 0, 0, 1);      // R5: jump
        cyc(5'd0, 5'd0, 5'd0, 0, 0, 0);      // R7
        cyc(5'd8, 5'd1, 5'd8, 1, 1, 0);      // R6: flush beats stall
        cyc(5'd8, 5'd1, 5'd8, 1, 0, 0);      // R7: hit ignored in squash slot
        cyc(5'd8, 5'd1, 5'd8, 1, 0, 0);      // R1: back in run, stalls
        cyc(5'd1, 5'd2, 5'd3, 0, 0, 1);      // R9: jump in hold cycle
        cyc(5'd1, 5'd2, 5'd3, 0, 0, 0);      // R7
        cyc(5'd4, 5'd5, 5'd5, 1, 0, 0);      // R1
        cyc(5'd4, 5'd5, 5'd5, 1, 1, 0);      // R9/R6: branch in hold cycle
        for (int i = 0; i < 3000; i++) begin
            cyc(W'($urandom_range(0, 3)), W'($urandom_range(0, 3)), W'($urandom_range(0, 3)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 7) == 0));
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule